// File: doc/BRIEF.md
# Antenna Carrier and Demodulator Sample Timer

This block derives every timing signal a contactless tag reader front end needs from one 8 MHz reference clock. A free-running counter splits the clock into a 4 MHz step grid and a 125 kHz antenna carrier. The carrier is delivered as two complementary driver levels with a shared output enable. When the drivers are turned off to send write modulation, the enable drops and both outputs release.

A one-cycle sample strobe fires once per carrier period. Its position is set by a signed phase code, counted in 4 MHz steps of 11.25 degrees and taken relative to the falling edge of the first driver output. The code is saturated to the usable window. It is captured only by a wake command, and reset loads a fixed default. A preload timer generates the window that charges the external hold capacitor before demodulation. Its delay depends on the cause: a drivers-on edge starts a short delay, while a wake or a reset waits for the clock-settled flag and then starts a longer delay. A ready flag reports that the window has finished.

Top module: `carrier_timing`

## Requirements
- R1: With the drivers enabled, `td1` is high for exactly 32 clocks and then low for exactly 32 clocks, so the carrier period is 64 clocks.
- R2: While `drv_en` is high, `td_oe` is 1 and `td2` is always the inverse of `td1`.
- R3: While `drv_en` is low, `td_oe`, `td1`, `td2` and `smp_strobe` are all 0.
- R4: The sample strobe is high for exactly one clock per carrier period. It is high in the clock that is 2·P clocks after the first low clock of `td1`, taken modulo 64, where P is the captured phase in steps. P = 0 coincides with the first low clock of `td1`, and negative P falls before it.
- R5: After reset, the captured phase is +1 step, so the strobe comes 2 clocks after the falling edge of `td1`.
- R6: `phase_code` (5-bit two's complement) is captured only in a cycle where `wake` is high. Changes at any other time, including across a driver off/on cycle, do not move the strobe.
- R7: Phase codes below −7 are taken as −7, and codes above +8 are taken as +8.
- R8: When `drv_en` rises outside a wait for clock settling, `preload` goes high after 2048 clocks and stays high for 1024 clocks.
- R9: After a reset or a `wake` pulse, `preload` stays low while `clk_ok` is low. After `clk_ok` is seen high, `preload` goes high after 4144 clocks and stays high for 1024 clocks.
- R10: `smp_strobe` is never high while `preload` is high.
- R11: `demod_ready` is low from a reset, wake or drivers-on trigger until the preload window ends, and is high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_en | input | 1 | Antenna drivers enabled (low during write gaps) |
| wake | input | 1 | Wake command pulse; captures the phase code |
| clk_ok | input | 1 | Reference clock settled |
| phase_code | input | 5 | Signed sample phase in 11.25-degree steps |
| td1 | output | 1 | Driver 1 level |
| td2 | output | 1 | Driver 2 level |
| td_oe | output | 1 | Driver output enable (0 = high impedance) |
| smp_strobe | output | 1 | One-clock demodulator sample pulse |
| preload | output | 1 | Hold-capacitor preload window |
| demod_ready | output | 1 | Preload finished, demodulator settled |

## Verification
The checker watches, on every cycle, the complementary drive levels and the quiet outputs while the drivers are off. It also checks the 32-clock run length of `td1`, the ban on strobes inside the preload window, the upper bound on the window length, and that ready stays low during the window. Only the bench scenarios can show where the strobe falls for each phase code, including the saturated codes, and that the phase holds when the code changes without a wake. The same applies to the exact delays before the window, which differ by trigger, and to the wait on the clock-settled flag.

// File: rtl/carrier_pkg.sv
`timescale 1ns/1ps
package carrier_pkg;

    // Preload window sequencer states
    typedef enum logic [1:0] {
        PL_IDLE = 2'd0,
        PL_ARM  = 2'd1,
        PL_WAIT = 2'd2,
        PL_ON   = 2'd3
    } pl_state_t;

    // Antenna driver pin bundle
    typedef struct packed {
        logic lvl_a;
        logic lvl_b;
        logic oe;
    } drive_t;

    // Clamp an integer into [lo, hi]
    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // Wrap an integer into [0, m)
    function automatic int wrap_mod(input int v, input int m);
        int r;
        r = v % m;
        if (r < 0) r = r + m;
        return r;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/carrier_divider.sv
`timescale 1ns/1ps
module carrier_divider #(
    parameter int CLK_PER_STEP   = 2,
    parameter int STEPS_PER_CYC  = 32,
    localparam int PERIOD        = CLK_PER_STEP * STEPS_PER_CYC,
    localparam int PW            = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] pos,
    output logic          carrier_hi
);
    localparam int HALF = PERIOD / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (pos == PW'(PERIOD - 1)) begin
            pos <= '0;
        end else begin
            pos <= pos + PW'(1);
        end
    end

    // High for the first half of the cycle, falling edge where pos reaches HALF
    assign carrier_hi = (pos < PW'(HALF));

endmodule

// File: rtl/phase_capture.sv
`timescale 1ns/1ps
module phase_capture
    import carrier_pkg::*;
#(
    parameter int CODE_W   = 5,
    parameter int PH_MIN   = -7,
    parameter int PH_MAX   = 8,
    parameter int PH_RESET = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic signed [CODE_W-1:0] code_in,
    output logic signed [CODE_W-1:0] phase_q
);
    logic signed [CODE_W-1:0] code_sat;

    always_comb begin
        code_sat = CODE_W'(clamp_int(int'(code_in), PH_MIN, PH_MAX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= CODE_W'(PH_RESET);
        end else if (load) begin
            phase_q <= code_sat;
        end
    end

endmodule

// File: rtl/strobe_gen.sv
`timescale 1ns/1ps
module strobe_gen
    import carrier_pkg::*;
#(
    parameter int CLK_PER_STEP  = 2,
    parameter int STEPS_PER_CYC = 32,
    parameter int CODE_W        = 5,
    localparam int PERIOD       = CLK_PER_STEP * STEPS_PER_CYC,
    localparam int PW           = $clog2(PERIOD)
) (
    input  logic [PW-1:0]            pos,
    input  logic signed [CODE_W-1:0] phase,
    output logic                     hit
);
    localparam int HALF = PERIOD / 2;

    int tgt;

    always_comb begin
        // Reference is the falling edge of the carrier at pos == HALF
        tgt = wrap_mod(HALF + int'(phase) * CLK_PER_STEP, PERIOD);
        hit = (pos == tgt[PW-1:0]);
    end

endmodule

// File: rtl/preload_timer.sv
`timescale 1ns/1ps
module preload_timer
    import carrier_pkg::*;
#(
    parameter int DLY_DRV  = 2048,
    parameter int DLY_WAKE = 4144,
    parameter int WIN_LEN  = 1024,
    localparam int CW      = $clog2(max3(DLY_DRV, DLY_WAKE, WIN_LEN) + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic wake,
    input  logic drv_rise,
    input  logic clk_ok,
    output logic window,
    output logic ready
);
    pl_state_t     state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PL_ARM;
            cnt   <= '0;
            lim   <= CW'(DLY_WAKE - 1);
        end else if (wake) begin
            state <= PL_ARM;
            cnt   <= '0;
            lim   <= CW'(DLY_WAKE - 1);
        end else if (drv_rise && state != PL_ARM) begin
            state <= PL_WAIT;
            cnt   <= '0;
            lim   <= CW'(DLY_DRV - 1);
        end else begin
            unique case (state)
                PL_ARM: begin
                    if (clk_ok) begin
                        state <= PL_WAIT;
                        cnt   <= '0;
                        lim   <= CW'(DLY_WAKE - 1);
                    end
                end
                PL_WAIT: begin
                    if (cnt == lim) begin
                        state <= PL_ON;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PL_ON: begin
                    if (cnt == CW'(WIN_LEN - 1)) begin
                        state <= PL_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    assign window = (state == PL_ON);
    assign ready  = (state == PL_IDLE);

endmodule

// File: rtl/carrier_timing.sv
`timescale 1ns/1ps
module carrier_timing
    import carrier_pkg::*;
#(
    parameter int CLK_PER_STEP  = 2,
    parameter int STEPS_PER_CYC = 32,
    parameter int CODE_W        = 5,
    parameter int PH_MIN        = -7,
    parameter int PH_MAX        = 8,
    parameter int PH_RESET      = 1,
    parameter int DLY_DRV       = 2048,
    parameter int DLY_WAKE      = 4144,
    parameter int WIN_LEN       = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drv_en,
    input  logic              wake,
    input  logic              clk_ok,
    input  logic [CODE_W-1:0] phase_code,
    output logic              td1,
    output logic              td2,
    output logic              td_oe,
    output logic              smp_strobe,
    output logic              preload,
    output logic              demod_ready
);
    localparam int PERIOD = CLK_PER_STEP * STEPS_PER_CYC;
    localparam int PW     = $clog2(PERIOD);

    logic [PW-1:0]            pos;
    logic                     carrier_hi;
    logic signed [CODE_W-1:0] phase_q;
    logic                     hit;
    logic                     drv_q;
    logic                     drv_rise;
    drive_t                   drv;

    carrier_divider #(
        .CLK_PER_STEP (CLK_PER_STEP),
        .STEPS_PER_CYC(STEPS_PER_CYC)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .pos       (pos),
        .carrier_hi(carrier_hi)
    );

    phase_capture #(
        .CODE_W  (CODE_W),
        .PH_MIN  (PH_MIN),
        .PH_MAX  (PH_MAX),
        .PH_RESET(PH_RESET)
    ) u_phase (
        .clk    (clk),
        .rst    (rst),
        .load   (wake),
        .code_in($signed(phase_code)),
        .phase_q(phase_q)
    );

    strobe_gen #(
        .CLK_PER_STEP (CLK_PER_STEP),
        .STEPS_PER_CYC(STEPS_PER_CYC),
        .CODE_W       (CODE_W)
    ) u_strobe (
        .pos  (pos),
        .phase(phase_q),
        .hit  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= 1'b0;
        end else begin
            drv_q <= drv_en;
        end
    end

    assign drv_rise = drv_en & ~drv_q;

    preload_timer #(
        .DLY_DRV (DLY_DRV),
        .DLY_WAKE(DLY_WAKE),
        .WIN_LEN (WIN_LEN)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .wake    (wake),
        .drv_rise(drv_rise),
        .clk_ok  (clk_ok),
        .window  (preload),
        .ready   (demod_ready)
    );

    always_comb begin
        if (drv_en) begin
            drv.lvl_a = carrier_hi;
            drv.lvl_b = (pos >= PW'(PERIOD / 2));
            drv.oe    = 1'b1;
        end else begin
            drv.lvl_a = 1'b0;
            drv.lvl_b = 1'b0;
            drv.oe    = 1'b0;
        end
    end

    assign td1        = drv.lvl_a;
    assign td2        = drv.lvl_b;
    assign td_oe      = drv.oe;
    assign smp_strobe = hit & drv_en & ~preload;

endmodule

// File: rtl/carrier_timing_chk.sv
`timescale 1ns/1ps
module carrier_timing_chk #(
    parameter int HALF_PERIOD = 32,
    parameter int WIN_LEN     = 1024
) (
    input logic clk,
    input logic rst,
    input logic drv_en,
    input logic td1,
    input logic td2,
    input logic td_oe,
    input logic smp_strobe,
    input logic preload,
    input logic demod_ready
);
    localparam int RW = $clog2(HALF_PERIOD + 1) + 1;
    localparam int LW = $clog2(WIN_LEN + 1) + 1;

    logic [RW-1:0] run;
    logic          prev_td1;
    logic          en_q;
    logic          armed;
    logic [LW-1:0] plen;
    logic          toggle;

    assign toggle = td_oe && en_q && (td1 != prev_td1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= '0;
            prev_td1 <= 1'b0;
            en_q     <= 1'b0;
            armed    <= 1'b0;
            plen     <= '0;
        end else begin
            prev_td1 <= td1;
            en_q     <= td_oe;
            if (!td_oe) begin
                run   <= '0;
                armed <= 1'b0;
            end else if (toggle) begin
                run   <= RW'(1);
                armed <= 1'b1;
            end else if (run != '1) begin
                run <= run + RW'(1);
            end
            if (preload) begin
                if (plen != '1) plen <= plen + LW'(1);
            end else begin
                plen <= '0;
            end
        end
    end

    AST_CARRIER_HALF: assert property (@(posedge clk) disable iff (rst)
        (toggle && armed) |-> (run == RW'(HALF_PERIOD)));  // R1

    AST_DRIVE_COMPL: assert property (@(posedge clk) disable iff (rst)
        td_oe |-> (td2 == !td1));  // R2

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> (!td_oe && !td1 && !td2 && !smp_strobe));  // R3

    AST_NO_STROBE_IN_PRELOAD: assert property (@(posedge clk) disable iff (rst)
        preload |-> !smp_strobe);  // R10

    AST_PRELOAD_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        preload |-> (plen < LW'(WIN_LEN)));  // R8

    AST_NOT_READY_IN_PRELOAD: assert property (@(posedge clk) disable iff (rst)
        preload |-> !demod_ready);  // R11

endmodule

bind carrier_timing carrier_timing_chk #(
    .HALF_PERIOD(CLK_PER_STEP * STEPS_PER_CYC / 2),
    .WIN_LEN    (WIN_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .drv_en     (drv_en),
    .td1        (td1),
    .td2        (td2),
    .td_oe      (td_oe),
    .smp_strobe (smp_strobe),
    .preload    (preload),
    .demod_ready(demod_ready)
);

// File: tb/tb_carrier_timing.sv
`timescale 1ns/1ps
module tb_carrier_timing;

    localparam int NV = 9;
    // Phase codes applied through wake, expected strobe offset from td1 fall, saturation flag
    localparam int VEC_CODE [NV] = '{0, 3, -7, 8, -8, 15, -16, -1, 7};
    localparam int VEC_POS  [NV] = '{0, 6, 50, 16, 50, 16, 50, 62, 14};
    localparam int VEC_SAT  [NV] = '{0, 0, 0, 0, 1, 1, 1, 0, 0};

    logic       clk = 1'b0;
    logic       rst;
    logic       drv_en;
    logic       wake;
    logic       clk_ok;
    logic [4:0] phase_code;
    logic       td1, td2, td_oe, smp_strobe, preload, demod_ready;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    carrier_timing dut (
        .clk        (clk),
        .rst        (rst),
        .drv_en     (drv_en),
        .wake       (wake),
        .clk_ok     (clk_ok),
        .phase_code (phase_code),
        .td1        (td1),
        .td2        (td2),
        .td_oe      (td_oe),
        .smp_strobe (smp_strobe),
        .preload    (preload),
        .demod_ready(demod_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Trigger was applied before the coming posedge; count low then high samples of preload
    task automatic measure_preload(input int exp_dly, input string req);
        int lows = 0;
        int highs = 0;
        int strb = 0;
        int rdy = 0;
        step();
        while (!preload) begin
            lows++;
            if (demod_ready) rdy++;
            step();
        end
        while (preload) begin
            highs++;
            if (smp_strobe) strb++;
            if (demod_ready) rdy++;
            step();
        end
        check(lows == exp_dly, {req, " preload delay"}, lows, exp_dly);
        check(highs == 1024, {req, " preload length"}, highs, 1024);
        check(strb == 0, "R10 strobe inside preload", strb, 0);
        check(rdy == 0, "R11 ready low before window end", rdy, 0);
        check(demod_ready == 1'b1, "R11 ready after window", int'(demod_ready), 1);
    endtask

    task automatic measure_phase(input int exp_pos, input string req);
        logic prev;
        int   nstb = 0;
        int   where = -1;
        int   hi = 0;
        int   bad = 0;
        prev = td1;
        step();
        while (!(prev == 1'b1 && td1 == 1'b0)) begin
            prev = td1;
            step();
        end
        for (int k = 0; k < 64; k++) begin
            if (smp_strobe) begin
                nstb++;
                where = k;
            end
            if (td1) hi++;
            if (td2 != !td1 || !td_oe) bad++;
            step();
        end
        check(nstb == 1, {req, " strobes per period"}, nstb, 1);
        check(where == exp_pos, {req, " strobe position"}, where, exp_pos);
        check(hi == 32, "R1 td1 high clocks per period", hi, 32);
        check(bad == 0, "R2 td2 complement and enable", bad, 0);
    endtask

    task automatic do_wake(input int code);
        phase_code = 5'(code);
        wake       = 1'b1;
        clk_ok     = 1'b0;
        step();
        wake       = 1'b0;
        phase_code = 5'd4;
        for (int i = 0; i < 20; i++) begin
            step();
            check(!preload && !demod_ready, "R9 hold until clock settled",
                  int'(preload), 0);
        end
        clk_ok = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int quiet;
        rst        = 1'b1;
        drv_en     = 1'b1;
        wake       = 1'b0;
        clk_ok     = 1'b0;
        phase_code = 5'd0;
        repeat (4) step();
        check(!preload, "R11 reset preload low", int'(preload), 0);
        check(!demod_ready, "R11 reset ready low", int'(demod_ready), 0);
        check(td_oe && (td2 == !td1), "R2 reset drive pair", int'(td2), int'(!td1));

        // R9: no window while the clock has not settled
        rst = 1'b0;
        quiet = 0;
        for (int i = 0; i < 200; i++) begin
            step();
            if (preload || demod_ready) quiet++;
        end
        check(quiet == 0, "R9 waits for clk_ok after reset", quiet, 0);
        clk_ok = 1'b1;
        measure_preload(4144, "R9");
        measure_phase(2, "R5");

        // Phase codes through wake
        for (int v = 0; v < NV; v++) begin
            do_wake(VEC_CODE[v]);
            measure_preload(4144, "R9");
            measure_phase(VEC_POS[v], (VEC_SAT[v] != 0) ? "R7" : "R4");
        end

        // R6: code change without wake does not move the strobe
        phase_code = 5'd5;
        repeat (150) step();
        measure_phase(14, "R6");

        // R3: drivers off
        drv_en = 1'b0;
        quiet = 0;
        for (int i = 0; i < 130; i++) begin
            step();
            if (td_oe || td1 || td2 || smp_strobe) quiet++;
        end
        check(quiet == 0, "R3 outputs released while off", quiet, 0);

        // R8: drivers on
        drv_en = 1'b1;
        measure_preload(2048, "R8");
        measure_phase(14, "R6");

        finish_run();
    end

endmodule